// File: doc/BRIEF.md
# Pin-Change Interrupt Bank

This block watches a bank of already-synchronized input pins and raises an interrupt whenever any of them changes level. Each pin can optionally pass through a small glitch filter before change detection, so that short pulses on noisy lines are dropped. Every detected change sets a per-pin pending flag. A per-pin mask decides which pending flags may drive the single bank interrupt line that goes to the system interrupt controller.

Software reaches the block through a simple word-addressed register port. Mask bits and filter enables are each changed through a pair of write-one-to-set and write-one-to-clear locations, and each has a status location that reads back the current value. Reading the pending location returns all pending flags and clears them in the same access. Read data is registered and is valid in the cycle after the read strobe.

Top module: `pinchg_irq`

Register word addresses: 0 mask set, 1 mask clear, 2 mask status, 3 pending (read clears), 4 filter set, 5 filter clear, 6 filter status. Reads of address 7 return zero. Writes to status or pending addresses have no effect.

## Requirements
- R1: A pin sets its pending bit on a rising and on a falling level change alike. With the filter off, the interrupt output reflects a change two clock edges after the new level is first sampled.
- R2: A read of address 3 returns the pending flags in the next cycle and clears every flag in the same access. Changes on masked pins are still recorded as pending.
- R3: A change detected in the same cycle as a read of address 3 stays pending after that read, and the read itself returns only the earlier flags.
- R4: Writing to address 0 sets the mask bits given by ones in the write data. Writing to address 1 clears them. Address 2 reads back the current mask.
- R5: The interrupt output is high exactly when some pending bit has its mask bit set.
- R6: Unmasking a pin whose pending bit is already set raises the interrupt output at the same clock edge as the mask write.
- R7: Writing all ones to address 1 masks every pin and drops the interrupt output at that edge.
- R8: Writing to address 4 enables the filter on the pins given by ones, writing to address 5 disables it, and address 6 reads the enables back.
- R9: On a filtered pin, a new level must be sampled on two consecutive edges before it counts. A one-cycle pulse is dropped, a two-cycle pulse is seen, and the interrupt output follows one edge later than without the filter.
- R10: After reset the mask is all zero, the pending flags are clear, every filter is off and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Registered bank interrupt line |

## Verification
The hardest case to reach from the ports is a level change that lands in the same cycle as a pending read. This is where a naive clear-on-read design loses the event. The stimulus first builds one pending flag. It then changes a second pin one edge before asserting the read strobe, so the detector fires exactly in the read cycle. Two back-to-back reads then show the old flag and the surviving new one. Filter behaviour is reached by timing pulses of one and two cycles against the clock, and by counting edges until the interrupt output rises.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK_SET  = 3'd0,
    SEL_MASK_CLR  = 3'd1,
    SEL_MASK_STAT = 3'd2,
    SEL_PEND      = 3'd3,
    SEL_FILT_SET  = 3'd4,
    SEL_FILT_CLR  = 3'd5,
    SEL_FILT_STAT = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/pinchg_filter.sv
module pinchg_filter #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] en_i,
  output logic [NPINS-1:0] lvl_o
);
  logic [NPINS-1:0] samp_q;
  logic [NPINS-1:0] lvl_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        samp_q[g] <= 1'b0;
        lvl_q[g]  <= 1'b0;
      end else begin
        samp_q[g] <= pin_i[g];
        if (!en_i[g]) begin
          lvl_q[g] <= pin_i[g];
        end else if (pin_i[g] == samp_q[g]) begin
          lvl_q[g] <= pin_i[g];
        end
      end
    end
  end

  assign lvl_o = lvl_q;

  // R9
  filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((lvl_q ^ $past(lvl_q)) & $past(en_i) & ($past(pin_i) ^ $past(pin_i, 2))) == '0);
endmodule

// File: rtl/pinchg_detect.sv
module pinchg_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] pend_o,
  output logic [NPINS-1:0] pend_nxt_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] chg;
  logic [NPINS-1:0] pend_nxt;

  always_comb begin
    chg      = lvl_i ^ prev_q;
    pend_nxt = (pend_q & ~{NPINS{clr_i}}) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_nxt;
    end
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = pend_nxt;

  // R2
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((pend_q & ~$past(lvl_i ^ prev_q)) == '0));

  // R3
  chg_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|(lvl_i ^ prev_q)) |=> ((pend_q & $past(lvl_i ^ prev_q)) == $past(lvl_i ^ prev_q)));
endmodule

// File: rtl/pinchg_regs.sv
module pinchg_regs
  import pinchg_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  mask_nxt_o,
  output logic [NPINS-1:0]  filt_en_o,
  output logic              rd_clr_o,
  output logic [NPINS-1:0]  rdata_o
);
  logic [NPINS-1:0] mask_q;
  logic [NPINS-1:0] filt_q;
  logic [NPINS-1:0] mask_nxt;
  logic [NPINS-1:0] filt_nxt;
  logic [NPINS-1:0] rdata_q;
  logic [NPINS-1:0] rd_mux;

  function automatic logic [NPINS-1:0] wsel(input logic hit, input logic [NPINS-1:0] d);
    return hit ? d : '0;
  endfunction

  always_comb begin
    mask_nxt = (mask_q | wsel(wr_i && addr_i == SEL_MASK_SET, wdata_i))
             & ~wsel(wr_i && addr_i == SEL_MASK_CLR, wdata_i);
    filt_nxt = (filt_q | wsel(wr_i && addr_i == SEL_FILT_SET, wdata_i))
             & ~wsel(wr_i && addr_i == SEL_FILT_CLR, wdata_i);
    case (addr_i)
      SEL_MASK_STAT: rd_mux = mask_q;
      SEL_PEND:      rd_mux = pend_i;
      SEL_FILT_STAT: rd_mux = filt_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      filt_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      filt_q <= filt_nxt;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_nxt;
  assign filt_en_o  = filt_q;
  assign rd_clr_o   = rd_i && addr_i == SEL_PEND;
  assign rdata_o    = rdata_q;

  // R7
  mask_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == SEL_MASK_CLR && wdata_i == '1) |=> (mask_q == '0));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == SEL_MASK_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
  import pinchg_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] pend_nxt;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] mask_nxt;
  logic [NPINS-1:0] filt_en;
  logic             rd_clr;
  logic             irq_q;

  pinchg_filter #(.NPINS(NPINS)) u_filter (
    .clk(clk), .rst(rst), .pin_i(pin_i), .en_i(filt_en), .lvl_o(lvl)
  );

  pinchg_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .lvl_i(lvl), .clr_i(rd_clr),
    .pend_o(pend), .pend_nxt_o(pend_nxt)
  );

  pinchg_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend), .mask_o(mask), .mask_nxt_o(mask_nxt),
    .filt_en_o(filt_en), .rd_clr_o(rd_clr), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_nxt & mask_nxt);
  end

  assign irq_o = irq_q;

  // R5
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(pend & mask));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && pend == '0 && mask == '0 && filt_en == '0));
endmodule

// File: tb/pinchg_irq_bench.sv
module pinchg_irq_bench;
  import pinchg_pkg::*;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  logic [N-1:0] got;

  always #5 clk = ~clk;

  pinchg_irq #(.NPINS(N)) u_pinchg_irq (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // {new pin levels, mask, expected pending, expected irq}
  localparam logic [127:0] VEC [5] = '{
    {32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF, 32'd0},
    {32'h0000_0F0F, 32'h0000_00F0, 32'h0000_0FF0, 32'd1},
    {32'h8000_0F0F, 32'h0000_000F, 32'h8000_0000, 32'd0},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0F0F, 32'd1},
    {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hA5A5_A5A5, 32'd0}
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    edges(4);
    rst = 1'b0;
    edges(1);
    // R10 reset state
    chk("R10 irq", {31'd0, irq}, 32'd0);
    bus_read(SEL_MASK_STAT, got); chk("R10 mask", got, '0);
    bus_read(SEL_FILT_STAT, got); chk("R10 filter", got, '0);
    bus_read(SEL_PEND, got);      chk("R10 pending", got, '0);

    // table walk: R1 both edges, R2 masked still recorded, R4 mask, R5 irq
    for (int i = 0; i < 5; i++) begin
      bus_write(SEL_MASK_CLR, '1);
      bus_write(SEL_MASK_SET, VEC[i][95:64]);
      bus_read(SEL_PEND, got);
      pins = VEC[i][127:96];
      edges(4);
      chk("R5 table irq", {31'd0, irq}, VEC[i][31:0]);
      bus_read(SEL_MASK_STAT, got); chk("R4 table mask", got, VEC[i][95:64]);
      bus_read(SEL_PEND, got);      chk("R1 table pending", got, VEC[i][63:32]);
    end

    pins = '0;
    bus_write(SEL_MASK_CLR, '1);
    edges(4);
    bus_read(SEL_PEND, got);

    // R4 set then partial clear
    bus_write(SEL_MASK_SET, 32'h0000_00F0);
    bus_write(SEL_MASK_CLR, 32'h0000_0030);
    bus_read(SEL_MASK_STAT, got); chk("R4 partial clear", got, 32'h0000_00C0);
    bus_write(SEL_MASK_CLR, '1);

    // R8 / R9 glitch filter on pin 0
    bus_write(SEL_FILT_SET, 32'h1);
    bus_read(SEL_FILT_STAT, got); chk("R8 filter on", got, 32'h1);
    pins[0] = 1'b1; edges(1); pins[0] = 1'b0; edges(4);
    bus_read(SEL_PEND, got); chk("R9 one-cycle pulse dropped", got, '0);
    pins[0] = 1'b1; edges(2); pins[0] = 1'b0; edges(4);
    bus_read(SEL_PEND, got); chk("R9 two-cycle pulse seen", got, 32'h1);
    pins[1] = 1'b1; edges(1); pins[1] = 1'b0; edges(4);
    bus_read(SEL_PEND, got); chk("R8 unfiltered pulse seen", got, 32'h2);
    bus_write(SEL_FILT_CLR, 32'h1);
    bus_read(SEL_FILT_STAT, got); chk("R8 filter off", got, '0);

    // R1 / R9 latency on pin 8
    bus_write(SEL_MASK_SET, 32'h100);
    pins[8] = 1'b1;
    edges(1); chk("R1 rise not yet", {31'd0, irq}, 32'd0);
    edges(1); chk("R1 rise after two edges", {31'd0, irq}, 32'd1);
    bus_read(SEL_PEND, got); chk("R2 read returns", got, 32'h100);
    chk("R2 irq drops after read", {31'd0, irq}, 32'd0);
    bus_write(SEL_FILT_SET, 32'h100);
    pins[8] = 1'b0;
    edges(2); chk("R9 filtered not yet", {31'd0, irq}, 32'd0);
    edges(1); chk("R9 fall after three edges", {31'd0, irq}, 32'd1);
    bus_read(SEL_PEND, got);
    bus_write(SEL_FILT_CLR, '1);
    bus_write(SEL_MASK_CLR, '1);

    // R6 unmask with stored change, R7 mask all
    pins[12] = 1'b1; edges(4);
    chk("R2 masked no irq", {31'd0, irq}, 32'd0);
    bus_write(SEL_MASK_SET, 32'h1000);
    chk("R6 irq on unmask", {31'd0, irq}, 32'd1);
    bus_write(SEL_MASK_CLR, '1);
    chk("R7 irq off", {31'd0, irq}, 32'd0);
    bus_read(SEL_MASK_STAT, got); chk("R7 mask cleared", got, '0);
    bus_read(SEL_PEND, got); chk("R2 masked recorded", got, 32'h1000);

    // R3 change coincident with pending read
    pins[4] = 1'b1; edges(4);
    @(negedge clk); pins[5] = 1'b1;
    @(negedge clk); rd = 1'b1; addr = SEL_PEND;
    @(negedge clk); rd = 1'b0;
    chk("R3 read sees old flags", rdata, 32'h10);
    bus_read(SEL_PEND, got); chk("R3 change kept", got, 32'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule